// File: doc/BRIEF.md
# Signed Sparse Vector-Matrix Multiplier

This block multiplies a vector of ROWS signed integers by a constant ROWS x COLS signed weight matrix. It produces COLS signed dot products at the same time. The matrix is fixed when the design is elaborated. It is split into two unsigned matrices: one holds the positive weights, the other holds the magnitudes of the negative weights. For each column and each half, the block builds a bit-serial dot-product unit. Each unit has an adder tree for every weight bit plane, followed by a one-cycle shift-and-add merge across the planes. A final bit-serial subtractor per column forms the positive result minus the negative result.

A pulse on the start input loads the whole input vector into per-row shift registers. These registers broadcast one bit per cycle, least significant bit first and sign-extended, to every column. The results leave the block in two forms. The first is a serial stream, one bit per column per cycle. The second is full-width words captured by a deserializer. The latency is fixed and does not depend on the weights or the data. Weight bits that are zero leave their adder inputs tied to a constant, so synthesis removes that logic. Cost therefore follows the number of set weight bits.

Top module: `sparse_vmm`

## Requirements
- R1: Once a run completes, `y_o[c*OUT_W +: OUT_W]` holds the exact two's-complement value of the sum over r of x[r]*W[r][c]. Here x[r] is `x_i[r*IN_W +: IN_W]` read as signed, W[r][c] is `WEIGHTS[(r*COLS+c)*WT_W +: WT_W]` read as signed, and OUT_W = IN_W + WT_W + clog2(ROWS).
- R2: If `start_i` is sampled high at a rising edge, `valid_o` is high for exactly one cycle, after the edge that comes OUT_W + clog2(ROWS) + 2 edges later. This count does not depend on the data or the weights.
- R3: `y_bit_vld_o` is high for OUT_W consecutive cycles. The first of these cycles follows the edge that comes clog2(ROWS) + 2 edges after the start edge. In the j-th of these cycles (j from 0), `y_bit_o[c]` carries bit j of column c's result.
- R4: `y_o` keeps its last result, unchanged, until the next completion.
- R5: A start sampled while a run is in flight discards that run. No `valid_o` appears for it, and the new result arrives with the R2 latency counted from the new start.
- R6: A column whose weights are all zero reads 0, whatever the inputs.
- R7: The extreme operands, every input at its most negative value times a column of most-negative weights, produce the exact positive sum without wrap-around.
- R8: After reset, or after a reset applied during a run, `valid_o` and `y_bit_vld_o` are low and `y_o` is zero until a new run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the input vector and begin a run |
| x_i | input | ROWS*IN_W | Signed input vector, row r at bits r*IN_W |
| y_o | output | COLS*OUT_W | Signed results, column c at bits c*OUT_W |
| valid_o | output | 1 | One-cycle completion pulse for all columns |
| y_bit_o | output | COLS | Serial result bit per column, LSB first |
| y_bit_vld_o | output | 1 | Marks the cycles in which `y_bit_o` is meaningful |

## Verification
The bench builds the block with 8 rows, 4 columns, 6-bit inputs and 5-bit weights. This gives a 3-level adder tree, 14-bit results and a 19-cycle latency, small enough that every cycle of a run is checked. The matrix mixes four kinds of column: one of mixed signs, one entirely positive, one filled with the most negative weight, and one of zeros. Together they cover the positive half alone, the negative half alone, both halves combined, and the constant-zero path. Saturated inputs push the carry chains to their full result width. Restart and mid-run reset cases exercise the pipeline clear.

// File: rtl/sparse_vmm_pkg.sv
package sparse_vmm_pkg;

  typedef enum logic {
    ADD_MODE = 1'b0,
    SUB_MODE = 1'b1
  } sadd_mode_e;

  // full-precision signed result width
  function automatic int unsigned result_width(input int unsigned in_w,
                                               input int unsigned wt_w,
                                               input int unsigned rows);
    return in_w + wt_w + $clog2(rows);
  endfunction

  // tree levels + plane merge + P-N subtract + result streaming
  function automatic int unsigned pipe_latency(input int unsigned out_w,
                                               input int unsigned rows);
    return out_w + $clog2(rows) + 2;
  endfunction

endpackage

// File: rtl/vmm_serial_add.sv
module vmm_serial_add
  import sparse_vmm_pkg::*;
#(
  parameter sadd_mode_e MODE = ADD_MODE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  output logic s_o
);
  localparam logic CY_INIT = (MODE == SUB_MODE);

  logic b_eff, cy_q, cy_d, s_d;

  assign b_eff = (MODE == SUB_MODE) ? ~b_i : b_i;
  assign {cy_d, s_d} = {1'b0, a_i} + {1'b0, b_eff} + {1'b0, cy_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cy_q <= CY_INIT;
      s_o  <= 1'b0;
    end else if (clr_i) begin
      cy_q <= CY_INIT;
      s_o  <= 1'b0;
    end else begin
      cy_q <= cy_d;
      s_o  <= s_d;
    end
  end
endmodule

// File: rtl/vmm_col_dot.sv
module vmm_col_dot
  import sparse_vmm_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned WT_W = 5,
  parameter logic [ROWS*WT_W-1:0] MAG = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [ROWS-1:0] a_i,
  output logic            s_o
);
  localparam int unsigned LOG_R = $clog2(ROWS);
  localparam int unsigned NL    = 1 << LOG_R;

  logic [WT_W-1:0] plane;
  logic [WT_W-1:0] horner;
  logic            unused_a;

  assign unused_a = ^a_i;

  // one adder tree per weight bit plane; zero weight bits tie the leaf off
  for (genvar k = 0; k < WT_W; k++) begin : g_plane
    logic [2*NL-1:1] nd;
    for (genvar l = 0; l < NL; l++) begin : g_leaf
      if (l < ROWS) begin : g_row
        if (MAG[l*WT_W+k]) begin : g_on
          assign nd[NL+l] = a_i[l];
        end else begin : g_off
          assign nd[NL+l] = 1'b0;
        end
      end else begin : g_pad
        assign nd[NL+l] = 1'b0;
      end
    end
    for (genvar i = 1; i < NL; i++) begin : g_node
      vmm_serial_add #(.MODE(ADD_MODE)) u_add (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (clr_i),
        .a_i   (nd[2*i]),
        .b_i   (nd[2*i+1]),
        .s_o   (nd[i])
      );
    end
    assign plane[k] = nd[1];
  end

  // Horner merge: the adder register doubles the higher-plane partial sum
  for (genvar k = 0; k < WT_W; k++) begin : g_merge
    if (k == WT_W - 1) begin : g_top
      vmm_serial_add #(.MODE(ADD_MODE)) u_m (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (clr_i),
        .a_i   (plane[k]),
        .b_i   (1'b0),
        .s_o   (horner[k])
      );
    end else begin : g_mid
      vmm_serial_add #(.MODE(ADD_MODE)) u_m (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (clr_i),
        .a_i   (plane[k]),
        .b_i   (horner[k+1]),
        .s_o   (horner[k])
      );
    end
  end

  assign s_o = horner[0];
endmodule

// File: rtl/sparse_vmm.sv
module sparse_vmm
  import sparse_vmm_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 4,
  parameter int unsigned IN_W = 6,
  parameter int unsigned WT_W = 5,
  parameter logic [ROWS*COLS*WT_W-1:0] WEIGHTS = {(ROWS*COLS){WT_W'(1)}},
  localparam int unsigned OUT_W = sparse_vmm_pkg::result_width(IN_W, WT_W, ROWS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ROWS*IN_W-1:0]  x_i,
  output logic [COLS*OUT_W-1:0] y_o,
  output logic                  valid_o,
  output logic [COLS-1:0]       y_bit_o,
  output logic                  y_bit_vld_o
);
  localparam int unsigned LOG_R = $clog2(ROWS);
  localparam int unsigned LAT   = pipe_latency(OUT_W, ROWS);
  localparam int unsigned CW    = $clog2(LAT + 1);

  // split one signed column into positive part or negative magnitude
  function automatic logic [ROWS*WT_W-1:0] split_col(input int col, input bit neg);
    logic [ROWS*WT_W-1:0] m;
    logic signed [WT_W-1:0] w;
    m = '0;
    for (int r = 0; r < ROWS; r++) begin
      w = WEIGHTS[(r*COLS+col)*WT_W +: WT_W];
      if (neg && (w < 0))       m[r*WT_W +: WT_W] = -w;
      else if (!neg && (w > 0)) m[r*WT_W +: WT_W] = w;
    end
    return m;
  endfunction

  logic [ROWS-1:0] a_bit;
  logic            run_q;
  logic [CW-1:0]   cnt_q;
  logic [COLS-1:0] p_bit, n_bit;
  logic            last_bit;

  // input broadcast: LSB first, sign bit replicated after the data
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [IN_W-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (start_i) sr_q <= x_i[r*IN_W +: IN_W];
      else              sr_q <= {sr_q[IN_W-1], sr_q[IN_W-1:1]};
    end
    assign a_bit[r] = sr_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(LAT - 1)) begin
          run_q   <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assign y_bit_vld_o = run_q && (cnt_q >= CW'(LOG_R + 2)) && (cnt_q <= CW'(LAT - 1));
  assign last_bit    = run_q && (cnt_q == CW'(LAT - 1)) && !start_i;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [ROWS*WT_W-1:0] PMAG = split_col(c, 1'b0);
    localparam logic [ROWS*WT_W-1:0] NMAG = split_col(c, 1'b1);
    localparam bit ZERO_COL = (PMAG == '0) && (NMAG == '0);

    logic [OUT_W-1:0] sh_q;

    vmm_col_dot #(.ROWS(ROWS), .WT_W(WT_W), .MAG(PMAG)) u_pos (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .a_i   (a_bit),
      .s_o   (p_bit[c])
    );

    vmm_col_dot #(.ROWS(ROWS), .WT_W(WT_W), .MAG(NMAG)) u_neg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .a_i   (a_bit),
      .s_o   (n_bit[c])
    );

    vmm_serial_add #(.MODE(SUB_MODE)) u_sub (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .a_i   (p_bit[c]),
      .b_i   (n_bit[c]),
      .s_o   (y_bit_o[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q                   <= '0;
        y_o[c*OUT_W +: OUT_W]  <= '0;
      end else if (y_bit_vld_o) begin
        sh_q <= {y_bit_o[c], sh_q[OUT_W-1:1]};
        if (last_bit) y_o[c*OUT_W +: OUT_W] <= {y_bit_o[c], sh_q[OUT_W-1:1]};
      end
    end

    if (ZERO_COL) begin : g_zchk
      a_r6_zero_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
        y_bit_o[c] == 1'b0);
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r3_stream_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(y_bit_vld_o) && !$past(start_i)) |-> valid_o);

  a_r4_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(y_o) |-> valid_o);

  a_r5_restart_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);
endmodule

// File: tb/sim_sparse_vmm.sv
module sim_sparse_vmm;
  localparam int ROWS  = 8;
  localparam int COLS  = 4;
  localparam int IN_W  = 6;
  localparam int WT_W  = 5;
  localparam int LOG_R = 3;
  localparam int OUT_W = IN_W + WT_W + LOG_R;
  localparam int LAT   = OUT_W + LOG_R + 2;

  // row-major: columns mixed / positive / most-negative / zero
  localparam int W_TAB [ROWS*COLS] = '{
     3,  1, -16, 0,
    -5,  2, -16, 0,
     7,  4, -16, 0,
    -1,  8, -16, 0,
     0, 15, -16, 0,
    12,  6, -16, 0,
    -9,  0, -16, 0,
    15, 11, -16, 0
  };

  function automatic logic [ROWS*COLS*WT_W-1:0] pack_w();
    logic [ROWS*COLS*WT_W-1:0] p;
    p = '0;
    for (int i = 0; i < ROWS*COLS; i++) p[i*WT_W +: WT_W] = WT_W'(W_TAB[i]);
    return p;
  endfunction

  localparam logic [ROWS*COLS*WT_W-1:0] WPK = pack_w();

  localparam int NV = 6;
  localparam int X_TAB [NV][ROWS] = '{
    '{  0,   0,   0,   0,   0,   0,   0,   0},
    '{  1,   1,   1,   1,   1,   1,   1,   1},
    '{-32, -32, -32, -32, -32, -32, -32, -32},
    '{ 31,  31,  31,  31,  31,  31,  31,  31},
    '{ 31, -32,  31, -32,  31, -32,  31, -32},
    '{  5,  -3,  17, -20,   0,   9, -11,   2}
  };
  localparam string X_TAG [NV] = '{"R1", "R1", "R7", "R7", "R1", "R1"};

  logic                  clk;
  logic                  rst_ni;
  logic                  start_i;
  logic [ROWS*IN_W-1:0]  x_i;
  logic [COLS*OUT_W-1:0] y_o;
  logic                  valid_o;
  logic [COLS-1:0]       y_bit_o;
  logic                  y_bit_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit summarized = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  sparse_vmm #(
    .ROWS(ROWS), .COLS(COLS), .IN_W(IN_W), .WT_W(WT_W), .WEIGHTS(WPK)
  ) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .x_i        (x_i),
    .y_o        (y_o),
    .valid_o    (valid_o),
    .y_bit_o    (y_bit_o),
    .y_bit_vld_o(y_bit_vld_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_dot(input int xs [ROWS], input int c);
    int s;
    s = 0;
    for (int r = 0; r < ROWS; r++) s += xs[r] * W_TAB[r*COLS+c];
    return s;
  endfunction

  task automatic drive_x(input int xs [ROWS]);
    for (int r = 0; r < ROWS; r++) x_i[r*IN_W +: IN_W] = IN_W'(xs[r]);
  endtask

  function automatic int col_word(input int c);
    logic signed [OUT_W-1:0] w;
    w = y_o[c*OUT_W +: OUT_W];
    return int'(w);
  endfunction

  task automatic run_vec(input int xs [ROWS], input string tag);
    int first_vld, vcnt, vld_at, npulse, e;
    logic [OUT_W-1:0] ser [COLS];
    first_vld = -1; vcnt = 0; vld_at = -1; npulse = 0;
    for (int c = 0; c < COLS; c++) ser[c] = '0;
    drive_x(xs);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n <= LAT + 3; n++) begin
      if (y_bit_vld_o) begin
        if (first_vld < 0) first_vld = n;
        if (vcnt < OUT_W)
          for (int c = 0; c < COLS; c++) ser[c][vcnt] = y_bit_o[c];
        vcnt++;
      end
      if (valid_o) begin
        npulse++;
        if (vld_at < 0) vld_at = n;
      end
      if (n == LAT) begin
        for (int c = 0; c < COLS; c++) begin
          e = ref_dot(xs, c);
          check(col_word(c) == e, (c == 3) ? "R6" : tag, col_word(c), e);
        end
      end
      @(negedge clk);
    end
    check(vld_at == LAT, "R2 latency", vld_at, LAT);
    check(npulse == 1, "R2 pulse count", npulse, 1);
    check(first_vld == LOG_R + 2, "R3 stream start", first_vld, LOG_R + 2);
    check(vcnt == OUT_W, "R3 stream length", vcnt, OUT_W);
    for (int c = 0; c < COLS; c++) begin
      e = ref_dot(xs, c);
      check(ser[c] == OUT_W'(e), "R3 serial bits", longint'(ser[c]), longint'(OUT_W'(e)));
      check(col_word(c) == e, "R4 hold", col_word(c), e);
    end
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog (all R)", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int xs [ROWS];
    int xb [ROWS];
    int seed;
    int seen;
    rst_ni  = 1'b0;
    start_i = 1'b0;
    x_i     = '0;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R8 reset valid", valid_o, 0);
    check(y_bit_vld_o == 1'b0, "R8 reset stream", y_bit_vld_o, 0);
    check(y_o == '0, "R8 reset word", (y_o == '0) ? 0 : 1, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(valid_o == 1'b0, "R8 idle valid", valid_o, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < ROWS; r++) xs[r] = X_TAB[v][r];
      run_vec(xs, X_TAG[v]);
    end

    // pseudo-random vectors
    seed = 32'h1ace;
    for (int v = 0; v < 16; v++) begin
      for (int r = 0; r < ROWS; r++) begin
        seed = seed * 1103515245 + 12345;
        xs[r] = ((seed >>> 16) & 63) - 32;
      end
      run_vec(xs, "R1");
    end

    // R5: restart in flight
    for (int r = 0; r < ROWS; r++) begin
      xs[r] = 31 - r;
      xb[r] = r * 3 - 12;
    end
    drive_x(xs);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0;
    for (int n = 0; n < 5; n++) begin
      if (valid_o) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R5 no early valid", seen, 0);
    run_vec(xb, "R5");

    // R8: reset during a run
    drive_x(xs);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(y_o == '0, "R8 mid-run reset word", (y_o == '0) ? 0 : 1, 0);
    check(y_bit_vld_o == 1'b0, "R8 mid-run reset stream", y_bit_vld_o, 0);
    rst_ni = 1'b1;
    seen = 0;
    for (int n = 0; n < LAT + 4; n++) begin
      if (valid_o || y_bit_vld_o) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 no result after reset", seen, 0);
    run_vec(xb, "R1");

    summary();
    $finish;
  end
endmodule